// File: doc/BRIEF.md
# Hot-Swap Channel Fault Timer and Recovery Controller

This block is the digital sequencer for one power-switch channel of a hot-swap controller. It watches two comparator flags: a current-limit flag, which means the analog loop is regulating current, and a fast flag for a hard short. From these it drives four outputs: a gate-drive enable, a short gate-pulldown strobe, a soft-start reset and an active-low fault line. Counted clock cycles replace the analog timing capacitor. A soft-start window, an overcurrent timeout and a fast-pulldown width are each a fixed number of cycles.

When the overcurrent timeout runs out, the channel shuts off. A mode input then picks how it recovers. In latched mode it stays off until enable is toggled. In retry mode it waits a fixed number of complete timeout periods and then restarts by itself. If the overload is still there after the restart, the channel faults again. Deasserting enable always returns the channel to a clean off state.

Top module: `hsw_channel_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, the channel goes to off: `gate_on_o`=0, `gate_pull_o`=0, `ss_rst_o`=1, `fault_n_o`=1. This holds regardless of the other inputs.
- R2: In off, `en_i`=1 at an edge starts a soft-start of SS_CYC cycles (`gate_on_o`=1, `ss_rst_o`=0). During soft-start, `ilim_i` does not start the timeout. Overcurrent timing begins only after soft-start ends.
- R3: With the gate on and not in soft-start, `ilim_i`=1 starts the timeout. If `ilim_i` is still 1 after TMO_CYC cycles, the next cycle shows `gate_on_o`=0, `ss_rst_o`=1 and `fault_n_o`=0.
- R4: If `ilim_i` returns to 0 before the timeout ends (including in its final cycle), no fault occurs. The gate stays on, and the next assertion of `ilim_i` gets a full TMO_CYC-cycle timeout.
- R5: With `auto_retry_i`=0 (latched mode) when the timeout ends, the gate stays off and `fault_n_o` stays 0 for as long as `en_i` stays 1. Setting `en_i` to 0 and then back to 1 releases the fault and starts a new soft-start.
- R6: With `auto_retry_i`=1 (retry mode) when the timeout ends, the channel waits RETRY_CNT complete timeout periods (RETRY_CNT×TMO_CYC cycles). On the next cycle it restarts soft-start, and `fault_n_o` returns to 1 in that same cycle.
- R7: If `ilim_i` is still 1 after the restart's soft-start, a new timeout runs and the channel faults again.
- R8: In soft-start or normal on, `short_i`=1 at an edge produces KICK_CYC cycles with `gate_pull_o`=1 and `gate_on_o`=0. The strobe keeps its full width even if `short_i` falls early. Afterwards, with no overcurrent, the gate returns on without a fault.
- R9: If `short_i` or `ilim_i` is still 1 when the strobe ends, the channel enters current regulation and the normal TMO_CYC timeout applies.
- R10: `en_i`=0 at an edge, in any state, turns the gate off, sets `ss_rst_o`=1, releases `fault_n_o` and clears the timer and the retry count.
- R11: When `en_i` falls in the same cycle that the timeout would end, enable wins: the channel goes to off and no fault appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable |
| auto_retry_i | input | 1 | Recovery policy: 1 = automatic retry, 0 = latched |
| ilim_i | input | 1 | Current-limit comparator flag |
| short_i | input | 1 | Fast hard-short comparator flag |
| gate_on_o | output | 1 | Gate drive enable |
| gate_pull_o | output | 1 | Fast gate pulldown strobe |
| ss_rst_o | output | 1 | Holds the soft-start ramp discharged |
| fault_n_o | output | 1 | Fault indication, active low |

## Verification
Two cases can land on the same cycle, and both are tested. In the first, the timeout expires in the same cycle that the overload disappears. The bench holds `ilim_i` for exactly TMO_CYC cycles, then drops it just before the expiring edge, and expects no fault and a fresh full timeout afterwards. In the second, `en_i` falls in the same expiring cycle. The bench expects the off state with `fault_n_o` high, which shows that enable takes priority over fault entry.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_LIMIT = 3'd3,
    ST_KICK  = 3'd4,
    ST_LATCH = 3'd5,
    ST_WAIT  = 3'd6
  } hsw_state_e;

  // width able to hold the largest of three cycle counts
  function automatic int unsigned span_width(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // cycles spent in the retry wait before a restart
  function automatic int unsigned retry_wait_cycles(input int unsigned tmo,
                                                    input int unsigned reps);
    return tmo * reps;
  endfunction

  // states in which the shared timer advances
  function automatic logic state_timed(input hsw_state_e s);
    return (s == ST_SOFT) || (s == ST_KICK) || (s == ST_LIMIT) || (s == ST_WAIT);
  endfunction

  // states that count as a fault
  function automatic logic state_faulted(input hsw_state_e s);
    return (s == ST_LATCH) || (s == ST_WAIT);
  endfunction

endpackage

// File: rtl/hsw_cycle_timer.sv
module hsw_cycle_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] last_i,
  output logic          term_o
);

  logic [CW-1:0] cnt_q;

  assign term_o = run_i && (cnt_q == last_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i || !run_i) begin
      cnt_q <= '0;
    end else if (term_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the running count never passes the terminal value of its window
  a_r3_cnt_in_window: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !clr_i) |-> (cnt_q <= last_i));

endmodule

// File: rtl/hsw_wrap_counter.sv
module hsw_wrap_counter #(
  parameter int unsigned N = 64,
  localparam int unsigned W = (N < 2) ? 1 : $clog2(N)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam logic [W-1:0] TOP = W'(N - 1);

  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == TOP);

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R6: the completed-period count stays within the configured number
  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= TOP);

  // R6: a count step happens only on a period boundary
  a_r6_step_on_inc: assert property (@(posedge clk_i) disable iff (rst_i)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/hsw_ctrl_fsm.sv
module hsw_ctrl_fsm
  import hsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       en_i,
  input  logic       auto_retry_i,
  input  logic       ilim_i,
  input  logic       short_i,
  input  logic       tmr_term_i,
  input  logic       rty_last_i,
  output hsw_state_e st_q_o,
  output hsw_state_e st_nxt_o,
  output logic       gate_on_o,
  output logic       gate_pull_o,
  output logic       ss_rst_o,
  output logic       fault_n_o
);

  hsw_state_e st_q;
  hsw_state_e st_nxt;
  logic       oc;

  assign oc = ilim_i || short_i;

  always_comb begin
    st_nxt = st_q;
    if (!en_i) begin
      st_nxt = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:   st_nxt = ST_SOFT;
        ST_SOFT: begin
          if (short_i)         st_nxt = ST_KICK;
          else if (tmr_term_i) st_nxt = ST_RUN;
        end
        ST_RUN: begin
          if (short_i)     st_nxt = ST_KICK;
          else if (ilim_i) st_nxt = ST_LIMIT;
        end
        ST_KICK: begin
          if (tmr_term_i) st_nxt = oc ? ST_LIMIT : ST_RUN;
        end
        ST_LIMIT: begin
          if (!oc)             st_nxt = ST_RUN;
          else if (tmr_term_i) st_nxt = auto_retry_i ? ST_WAIT : ST_LATCH;
        end
        ST_LATCH: st_nxt = ST_LATCH;
        ST_WAIT: begin
          if (tmr_term_i && rty_last_i) st_nxt = ST_SOFT;
        end
        default:  st_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= ST_OFF;
    else       st_q <= st_nxt;
  end

  assign gate_on_o   = (st_q == ST_SOFT) || (st_q == ST_RUN) || (st_q == ST_LIMIT);
  assign gate_pull_o = (st_q == ST_KICK);
  assign ss_rst_o    = (st_q == ST_OFF) || state_faulted(st_q);
  assign fault_n_o   = !state_faulted(st_q);
  assign st_q_o      = st_q;
  assign st_nxt_o    = st_nxt;

  // R10: a low enable leaves the channel off with the fault released
  a_r10_enable_off: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!gate_on_o && ss_rst_o && fault_n_o));

  // R5: a latched fault survives as long as enable stays high
  a_r5_latch_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_q == ST_LATCH) && en_i) |=> (st_q == ST_LATCH));

  // R3: a fault appears only after an expiring timeout with overcurrent present
  a_r3_fault_needs_expiry: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(fault_n_o) |-> $past((st_q == ST_LIMIT) && tmr_term_i && oc));

  // R8: the pulldown strobe is not cut short before its window ends
  a_r8_kick_full_width: assert property (@(posedge clk_i) disable iff (rst_i)
    (gate_pull_o && !tmr_term_i && en_i) |=> gate_pull_o);

endmodule

// File: rtl/hsw_channel_ctrl.sv
module hsw_channel_ctrl
  import hsw_pkg::*;
#(
  parameter int unsigned TMO_CYC   = 16,
  parameter int unsigned SS_CYC    = 8,
  parameter int unsigned KICK_CYC  = 2,
  parameter int unsigned RETRY_CNT = 64
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic auto_retry_i,
  input  logic ilim_i,
  input  logic short_i,
  output logic gate_on_o,
  output logic gate_pull_o,
  output logic ss_rst_o,
  output logic fault_n_o
);

  localparam int unsigned CW = span_width(TMO_CYC, SS_CYC, KICK_CYC);
  localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] SS_LAST   = CW'(SS_CYC - 1);
  localparam logic [CW-1:0] KICK_LAST = CW'(KICK_CYC - 1);

  hsw_state_e    st_q;
  hsw_state_e    st_nxt;
  logic          tmr_clr;
  logic          tmr_run;
  logic          tmr_term;
  logic [CW-1:0] tmr_last;
  logic          rty_clr;
  logic          rty_inc;
  logic          rty_last;

  assign tmr_clr = (st_nxt != st_q);
  assign tmr_run = state_timed(st_q);

  always_comb begin
    unique case (st_q)
      ST_SOFT:  tmr_last = SS_LAST;
      ST_KICK:  tmr_last = KICK_LAST;
      ST_LIMIT: tmr_last = TMO_LAST;
      ST_WAIT:  tmr_last = TMO_LAST;
      default:  tmr_last = '0;
    endcase
  end

  assign rty_clr = (st_q != ST_WAIT) || tmr_clr;
  assign rty_inc = (st_q == ST_WAIT) && tmr_term;

  hsw_cycle_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (tmr_clr),
    .run_i  (tmr_run),
    .last_i (tmr_last),
    .term_o (tmr_term)
  );

  hsw_wrap_counter #(.N(RETRY_CNT)) u_retry (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (rty_clr),
    .inc_i  (rty_inc),
    .last_o (rty_last)
  );

  hsw_ctrl_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .en_i         (en_i),
    .auto_retry_i (auto_retry_i),
    .ilim_i       (ilim_i),
    .short_i      (short_i),
    .tmr_term_i   (tmr_term),
    .rty_last_i   (rty_last),
    .st_q_o       (st_q),
    .st_nxt_o     (st_nxt),
    .gate_on_o    (gate_on_o),
    .gate_pull_o  (gate_pull_o),
    .ss_rst_o     (ss_rst_o),
    .fault_n_o    (fault_n_o)
  );

  // R6: a restart out of the retry wait follows the final counted period
  a_r6_restart_after_wait: assert property (@(posedge clk_i) disable iff (rst_i)
    ((st_q == ST_SOFT) && ($past(st_q) == ST_WAIT)) |-> $past(tmr_term && rty_last));

  // R6: the fault line rises while enabled only at a restart
  a_r6_clear_at_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(fault_n_o) && $past(en_i)) |-> (gate_on_o && !ss_rst_o));

  // R1: reset leaves the channel off with the fault released
  a_r1_reset_off: assert property (@(posedge clk_i)
    rst_i |=> (!gate_on_o && !gate_pull_o && ss_rst_o && fault_n_o));

endmodule

// File: tb/tb_hsw_channel_ctrl.sv
module tb_hsw_channel_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 16;
  localparam int SS   = 8;
  localparam int KICK = 2;
  localparam int REPS = 64;
  localparam int WD_CYCLES = 60000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic auto_retry = 1'b0;
  logic ilim = 1'b0;
  logic short_f = 1'b0;
  logic gate_on, gate_pull, ss_rst, fault_n;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsw_channel_ctrl #(
    .TMO_CYC(TMO), .SS_CYC(SS), .KICK_CYC(KICK), .RETRY_CNT(REPS)
  ) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .auto_retry_i(auto_retry),
    .ilim_i(ilim), .short_i(short_f),
    .gate_on_o(gate_on), .gate_pull_o(gate_pull),
    .ss_rst_o(ss_rst), .fault_n_o(fault_n)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // expected {gate_on, gate_pull, ss_rst, fault_n}
  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {gate_on, gate_pull, ss_rst, fault_n};
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: {gate,pull,ssrst,fltn} actual=%b expected=%b at %0t",
                  req, act, exp, $time);
  endtask

  localparam logic [3:0] O_OFF   = 4'b0011;
  localparam logic [3:0] O_ON    = 4'b1001;
  localparam logic [3:0] O_FAULT = 4'b0010;
  localparam logic [3:0] O_KICK  = 4'b0101;

  task automatic go_off();
    en = 1'b0; ilim = 1'b0; short_f = 1'b0;
    tick(1);
  endtask

  task automatic bring_up();
    go_off();
    en = 1'b1;
    tick(SS + 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; ilim = 1'b1; short_f = 1'b1;
    tick(3);
    expect_out("R1", O_OFF);
    rst = 1'b0; en = 1'b0; ilim = 1'b0; short_f = 1'b0;
    tick(1);
    expect_out("R1", O_OFF);
  endtask

  task automatic t_softstart();
    go_off();
    auto_retry = 1'b0; ilim = 1'b1; en = 1'b1;
    tick(1);
    expect_out("R2 soft-start entry", O_ON);
    tick(SS + TMO);
    expect_out("R2 ilim ignored during soft-start", O_ON);
    tick(1);
    expect_out("R2 timeout counted after soft-start", O_FAULT);
  endtask

  task automatic t_timeout_latch();
    bring_up();
    auto_retry = 1'b0; ilim = 1'b1;
    tick(TMO);
    expect_out("R3 before expiry", O_ON);
    tick(1);
    expect_out("R3 expiry fault", O_FAULT);
    ilim = 1'b0;
    tick(REPS * TMO + 20);
    expect_out("R5 latched hold", O_FAULT);
    en = 1'b0;
    tick(1);
    expect_out("R5 enable low releases", O_OFF);
    en = 1'b1;
    tick(1);
    expect_out("R5 re-enable restarts", O_ON);
  endtask

  task automatic t_drop();
    bring_up();
    auto_retry = 1'b0; ilim = 1'b1;
    tick(TMO);
    ilim = 1'b0;
    tick(1);
    expect_out("R4 drop in final cycle", O_ON);
    ilim = 1'b1;
    tick(TMO);
    expect_out("R4 fresh full timeout", O_ON);
    tick(1);
    expect_out("R4 fault after fresh timeout", O_FAULT);
  endtask

  task automatic t_retry();
    bring_up();
    auto_retry = 1'b1; ilim = 1'b1;
    tick(TMO + 1);
    expect_out("R6 retry fault", O_FAULT);
    tick(REPS * TMO - 1);
    expect_out("R6 end of wait", O_FAULT);
    tick(1);
    expect_out("R6 restart clears fault", O_ON);
    tick(SS + TMO);
    expect_out("R7 regulating after restart", O_ON);
    tick(1);
    expect_out("R7 repeat fault", O_FAULT);
  endtask

  task automatic t_kick();
    bring_up();
    auto_retry = 1'b0;
    short_f = 1'b1;
    tick(1);
    expect_out("R8 strobe start", O_KICK);
    short_f = 1'b0;
    tick(KICK - 1);
    expect_out("R8 strobe full width", O_KICK);
    tick(1);
    expect_out("R8 gate released", O_ON);
    tick(TMO + 5);
    expect_out("R8 no fault after short", O_ON);
  endtask

  task automatic t_kick_hold();
    bring_up();
    auto_retry = 1'b0;
    short_f = 1'b1;
    tick(KICK);
    expect_out("R9 strobe", O_KICK);
    tick(TMO);
    expect_out("R9 regulating", O_ON);
    tick(1);
    expect_out("R9 timeout fault", O_FAULT);
  endtask

  task automatic t_disable();
    bring_up();
    auto_retry = 1'b1; ilim = 1'b1;
    tick(TMO + 1 + 40);
    expect_out("R10 in retry wait", O_FAULT);
    en = 1'b0;
    tick(1);
    expect_out("R10 enable low mid-wait", O_OFF);
    en = 1'b1; ilim = 1'b1;
    tick(1);
    expect_out("R10 clean soft-start", O_ON);
    tick(SS + TMO);
    expect_out("R10 timer cleared", O_ON);
    tick(1);
    expect_out("R10 fault after full windows", O_FAULT);
  endtask

  task automatic t_race();
    bring_up();
    auto_retry = 1'b0; ilim = 1'b1;
    tick(TMO);
    en = 1'b0;
    tick(1);
    expect_out("R11 enable wins over expiry", O_OFF);
    tick(5);
    expect_out("R11 stays off", O_OFF);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_softstart();
    t_timeout_latch();
    t_drop();
    t_retry();
    t_kick();
    t_kick_hold();
    t_disable();
    t_race();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

endmodule